// File: doc/BRIEF.md
# USB Transmit Endpoint FIFO Controller

This block holds the outgoing bytes of one USB function endpoint. Firmware pushes data bytes into a small ring buffer, then writes a 16-bit packet length as two halves; writing the low half commits the length and arms the endpoint. When the serial interface engine reports an IN token, the block decides in the next cycle whether the token is answered with data or with a NAK. If it grants data, the engine pulls bytes one strobe at a time and ends the packet with a good or a bad end-of-packet indication.

A good end of packet frees the bytes the engine has read and disarms the endpoint. A bad end of packet rewinds the read position so the same bytes go out again on the next token. Reading past the stored data raises a sticky underrun flag that forces NAKs until firmware issues a clear. The clear takes priority over every other event in the same cycle. A pending setup indication holds off data responses, and lowering it has no lasting effect on the endpoint.

Top module: `usb_tx_ep_fifo`

## Requirements
- R1: After reset, flg_empty is 1, flg_full, flg_underrun, flg_overflow and flg_ready are 0, tx_len and fill_level are 0, and sie_resp_valid is 0.
- R2: flg_ready is 1 only when fill_level is non-zero and a length has been committed by a low-half write since the last clear or good end of packet. Data bytes alone, or a high-half write alone, leave it 0.
- R3: An IN token (sie_in_tok high for one cycle) while flg_ready is 0 gives sie_resp_valid=1 and sie_resp_nak=1 in the following cycle. In any cycle without a token, sie_resp_valid is 0 in the next cycle.
- R4: An IN token while flg_ready is 1, with no underrun and setup_pend low, gives sie_resp_valid=1 and sie_resp_nak=0 in the following cycle. Each later sie_rd strobe presents the next unread byte on sie_rd_data in the same cycle, in write order.
- R5: A sie_rd strobe when no unread byte remains shows 0 on sie_rd_data and sets flg_underrun from the next cycle on. The flag stays set until a clear, and every IN token meanwhile is NAKed, even after new data and a new length are written.
- R6: A high-half write only stages a byte. A low-half write commits {staged high, written low} to tx_len in the next cycle; with both strobes in one cycle the written byte fills both halves. The length resets to 0.
- R7: fw_clr empties the buffer, clears flg_underrun, flg_overflow, flg_full and flg_ready, and sets flg_empty from the next cycle on. A token in the same cycle is NAKed, and a byte strobe in the same cycle does not cause underrun, even with setup_pend high.
- R8: While setup_pend is high, every IN token is NAKed. Once setup_pend falls, the next token on an armed endpoint is answered with data.
- R9: sie_eop_ok frees the bytes read since the packet began and clears flg_ready. Unread bytes stay, and fill_level drops by the number read.
- R10: sie_eop_bad rewinds the read position to the first byte of the packet and keeps flg_ready. The next granted token resends the same bytes.
- R11: flg_full is 1 when fill_level equals DEPTH. A byte written while full is dropped and sets the sticky flg_overflow, which a clear resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fw_wr_en | input | 1 | Firmware data byte strobe |
| fw_wr_data | input | DW (8) | Firmware data byte |
| fw_cnt_hi_we | input | 1 | Stage the high length half |
| fw_cnt_lo_we | input | 1 | Write the low length half and commit |
| fw_cnt_data | input | CW/2 (8) | Length half value |
| fw_clr | input | 1 | Clear command |
| setup_pend | input | 1 | Setup packet pending, holds off data |
| sie_in_tok | input | 1 | IN token arrived |
| sie_rd | input | 1 | Engine byte strobe |
| sie_rd_data | output | DW (8) | Byte under the read position, 0 when none |
| sie_eop_ok | input | 1 | Packet sent and acknowledged |
| sie_eop_bad | input | 1 | Packet failed, resend |
| sie_resp_valid | output | 1 | Token response valid |
| sie_resp_nak | output | 1 | Token answered with NAK |
| tx_len | output | CW (16) | Committed packet length |
| fill_level | output | $clog2(DEPTH)+1 (4) | Bytes held |
| flg_empty | output | 1 | No bytes held |
| flg_full | output | 1 | DEPTH bytes held |
| flg_underrun | output | 1 | Sticky underrun |
| flg_overflow | output | 1 | Sticky overflow |
| flg_ready | output | 1 | Transmit-ready |

## Verification
A token response is registered, so it is due exactly one cycle after the token and lasts that one cycle. Flags, fill level and length move on the edge that captures the write, clear, strobe or end of packet. Read data is combinational and is valid while the strobe is still high. The bench drives every input on a falling edge and holds it across one rising edge. It then reads flags and responses at the next falling edge, and reads the byte 1 ns into the strobe cycle, so each value is sampled in the cycle it is due.

// File: rtl/tx_ep_pkg.sv
`timescale 1ns/1ps
package tx_ep_pkg;
   // pointer events handed from the response logic to the pointer set
   typedef struct packed {
      logic push;
      logic pop;
      logic commit;
      logic rewind;
   } ptr_ops_t;

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tx_ep_store.sv
`timescale 1ns/1ps
module tx_ep_store #(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] slot [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == AW'(g))) slot[g] <= wr_data;
      end
   end

   assign rd_data = slot[rd_idx];
endmodule

// File: rtl/tx_ep_ptrs.sv
`timescale 1ns/1ps
module tx_ep_ptrs
   import tx_ep_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  ptr_ops_t      ops,
   output logic [AW-1:0] wr_idx,
   output logic [AW-1:0] rd_idx,
   output logic [PW-1:0] level,
   output logic          full,
   output logic          avail
);
   logic [PW-1:0] wp, rp, sp;   // write, packet start, read position
   logic [PW-1:0] sp_nxt;

   assign level  = wp - rp;
   assign full   = (level == PW'(DEPTH));
   assign avail  = (wp != sp);
   assign wr_idx = wp[AW-1:0];
   assign rd_idx = sp[AW-1:0];

   always_comb begin
      sp_nxt = ops.pop ? sp + PW'(1) : sp;
      if (ops.rewind && !ops.commit) sp_nxt = rp;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
         sp <= '0;
      end else if (clr) begin
         wp <= '0;
         rp <= '0;
         sp <= '0;
      end else begin
         if (ops.push) wp <= wp + PW'(1);
         sp <= sp_nxt;
         if (ops.commit) rp <= sp_nxt;
      end
   end
endmodule

// File: rtl/tx_ep_count.sv
`timescale 1ns/1ps
module tx_ep_count #(
   parameter int CW  = 16,
   localparam int HW = CW / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          hi_we,
   input  logic          lo_we,
   input  logic [HW-1:0] din,
   input  logic          release_i,
   output logic [CW-1:0] len,
   output logic          armed
);
   logic [HW-1:0] hi_stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_stage <= '0;
         len      <= '0;
         armed    <= 1'b0;
      end else begin
         if (hi_we) hi_stage <= din;
         if (lo_we) len <= {(hi_we ? din : hi_stage), din};
         if (clr)            armed <= 1'b0;
         else if (lo_we)     armed <= 1'b1;
         else if (release_i) armed <= 1'b0;
      end
   end
endmodule

// File: rtl/tx_ep_resp.sv
`timescale 1ns/1ps
module tx_ep_resp
   import tx_ep_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr,
   input  logic     in_tok,
   input  logic     setup_pend,
   input  logic     ready,
   input  logic     wr_req,
   input  logic     rd_req,
   input  logic     eop_ok,
   input  logic     eop_bad,
   input  logic     full,
   input  logic     avail,
   output ptr_ops_t ops,
   output logic     resp_valid,
   output logic     resp_nak,
   output logic     underrun,
   output logic     overflow
);
   logic grant;
   logic rd_miss;

   assign grant      = in_tok && !clr && ready && !underrun && !setup_pend;
   assign rd_miss    = rd_req && !avail && !clr;
   assign ops.push   = wr_req && !full && !clr;
   assign ops.pop    = rd_req && avail && !clr;
   assign ops.commit = eop_ok && !clr;
   assign ops.rewind = eop_bad && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_nak   <= 1'b0;
         underrun   <= 1'b0;
         overflow   <= 1'b0;
      end else begin
         resp_valid <= in_tok;
         resp_nak   <= in_tok && !grant;
         if (clr)          underrun <= 1'b0;
         else if (rd_miss) underrun <= 1'b1;
         if (clr)                  overflow <= 1'b0;
         else if (wr_req && full)  overflow <= 1'b1;
      end
   end
endmodule

// File: rtl/usb_tx_ep_fifo.sv
`timescale 1ns/1ps
module usb_tx_ep_fifo
   import tx_ep_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   parameter int CW    = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fw_wr_en,
   input  logic [DW-1:0] fw_wr_data,
   input  logic          fw_cnt_hi_we,
   input  logic          fw_cnt_lo_we,
   input  logic [CW/2-1:0] fw_cnt_data,
   input  logic          fw_clr,
   input  logic          setup_pend,
   input  logic          sie_in_tok,
   input  logic          sie_rd,
   output logic [DW-1:0] sie_rd_data,
   input  logic          sie_eop_ok,
   input  logic          sie_eop_bad,
   output logic          sie_resp_valid,
   output logic          sie_resp_nak,
   output logic [CW-1:0] tx_len,
   output logic [PW-1:0] fill_level,
   output logic          flg_empty,
   output logic          flg_full,
   output logic          flg_underrun,
   output logic          flg_overflow,
   output logic          flg_ready
);
   if (!is_pow2(DEPTH)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if ((CW < 2) || (CW % 2 != 0)) begin : g_bad_cw
      $error("CW must be even and at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   ptr_ops_t      ops;
   logic [AW-1:0] wr_idx, rd_idx;
   logic          full, avail, armed;
   logic [DW-1:0] slot_data;

   tx_ep_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk     (clk),
      .wr_en   (ops.push),
      .wr_idx  (wr_idx),
      .wr_data (fw_wr_data),
      .rd_idx  (rd_idx),
      .rd_data (slot_data)
   );

   tx_ep_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (fw_clr),
      .ops    (ops),
      .wr_idx (wr_idx),
      .rd_idx (rd_idx),
      .level  (fill_level),
      .full   (full),
      .avail  (avail)
   );

   tx_ep_count #(.CW(CW)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (fw_clr),
      .hi_we     (fw_cnt_hi_we),
      .lo_we     (fw_cnt_lo_we),
      .din       (fw_cnt_data),
      .release_i (sie_eop_ok),
      .len       (tx_len),
      .armed     (armed)
   );

   tx_ep_resp u_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (fw_clr),
      .in_tok     (sie_in_tok),
      .setup_pend (setup_pend),
      .ready      (flg_ready),
      .wr_req     (fw_wr_en),
      .rd_req     (sie_rd),
      .eop_ok     (sie_eop_ok),
      .eop_bad    (sie_eop_bad),
      .full       (full),
      .avail      (avail),
      .ops        (ops),
      .resp_valid (sie_resp_valid),
      .resp_nak   (sie_resp_nak),
      .underrun   (flg_underrun),
      .overflow   (flg_overflow)
   );

   assign sie_rd_data = avail ? slot_data : '0;
   assign flg_empty   = (fill_level == '0);
   assign flg_full    = full;
   assign flg_ready   = !flg_empty && armed;
endmodule

// File: rtl/tx_ep_fifo_chk.sv
`timescale 1ns/1ps
module tx_ep_fifo_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fw_wr_en,
   input logic          fw_cnt_lo_we,
   input logic [CW/2-1:0] fw_cnt_data,
   input logic          fw_clr,
   input logic          setup_pend,
   input logic          sie_in_tok,
   input logic          sie_eop_ok,
   input logic          sie_resp_valid,
   input logic          sie_resp_nak,
   input logic [CW-1:0] tx_len,
   input logic          flg_empty,
   input logic          flg_full,
   input logic          flg_underrun,
   input logic          flg_overflow,
   input logic          flg_ready
);
   p_no_tok_no_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sie_in_tok |=> !sie_resp_valid);

   p_nak_not_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sie_in_tok && !flg_ready |=> sie_resp_valid && sie_resp_nak);

   p_underrun_nak_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sie_in_tok && flg_underrun |=> sie_resp_nak);

   p_underrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flg_underrun && !fw_clr |=> flg_underrun);

   p_len_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fw_cnt_lo_we |=> tx_len[CW/2-1:0] == $past(fw_cnt_data));

   p_clear_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fw_clr |=> flg_empty && !flg_underrun && !flg_overflow && !flg_ready && !flg_full);

   p_setup_nak_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sie_in_tok && setup_pend |=> sie_resp_nak);

   p_eop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sie_eop_ok && !fw_cnt_lo_we |=> !flg_ready);

   p_full_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fw_wr_en && flg_full && !fw_clr && !sie_eop_ok |=> flg_overflow && flg_full);
endmodule

bind usb_tx_ep_fifo tx_ep_fifo_chk #(.CW(CW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .fw_wr_en       (fw_wr_en),
   .fw_cnt_lo_we   (fw_cnt_lo_we),
   .fw_cnt_data    (fw_cnt_data),
   .fw_clr         (fw_clr),
   .setup_pend     (setup_pend),
   .sie_in_tok     (sie_in_tok),
   .sie_eop_ok     (sie_eop_ok),
   .sie_resp_valid (sie_resp_valid),
   .sie_resp_nak   (sie_resp_nak),
   .tx_len         (tx_len),
   .flg_empty      (flg_empty),
   .flg_full       (flg_full),
   .flg_underrun   (flg_underrun),
   .flg_overflow   (flg_overflow),
   .flg_ready      (flg_ready)
);

// File: tb/usb_tx_ep_fifo_tb.sv
`timescale 1ns/1ps
module usb_tx_ep_fifo_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fw_wr_en = 0, fw_cnt_hi_we = 0, fw_cnt_lo_we = 0, fw_clr = 0;
   logic [7:0] fw_wr_data = '0, fw_cnt_data = '0;
   logic       setup_pend = 0, sie_in_tok = 0, sie_rd = 0, sie_eop_ok = 0, sie_eop_bad = 0;
   logic [7:0] sie_rd_data;
   logic       sie_resp_valid, sie_resp_nak;
   logic [15:0] tx_len;
   logic [3:0] fill_level;
   logic       flg_empty, flg_full, flg_underrun, flg_overflow, flg_ready;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   usb_tx_ep_fifo u_dut (
      .clk(clk), .rst_n(rst_n), .fw_wr_en(fw_wr_en), .fw_wr_data(fw_wr_data),
      .fw_cnt_hi_we(fw_cnt_hi_we), .fw_cnt_lo_we(fw_cnt_lo_we), .fw_cnt_data(fw_cnt_data),
      .fw_clr(fw_clr), .setup_pend(setup_pend), .sie_in_tok(sie_in_tok), .sie_rd(sie_rd),
      .sie_rd_data(sie_rd_data), .sie_eop_ok(sie_eop_ok), .sie_eop_bad(sie_eop_bad),
      .sie_resp_valid(sie_resp_valid), .sie_resp_nak(sie_resp_nak), .tx_len(tx_len),
      .fill_level(fill_level), .flg_empty(flg_empty), .flg_full(flg_full),
      .flg_underrun(flg_underrun), .flg_overflow(flg_overflow), .flg_ready(flg_ready)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // every action starts and ends at a falling edge
   task automatic wr_byte(input logic [7:0] b);
      fw_wr_en = 1; fw_wr_data = b;
      @(negedge clk);
      fw_wr_en = 0;
   endtask

   task automatic wr_hi(input logic [7:0] v);
      fw_cnt_hi_we = 1; fw_cnt_data = v;
      @(negedge clk);
      fw_cnt_hi_we = 0;
   endtask

   task automatic wr_lo(input logic [7:0] v);
      fw_cnt_lo_we = 1; fw_cnt_data = v;
      @(negedge clk);
      fw_cnt_lo_we = 0;
   endtask

   task automatic do_clr();
      fw_clr = 1;
      @(negedge clk);
      fw_clr = 0;
   endtask

   task automatic token(output logic v, output logic nak);
      sie_in_tok = 1;
      @(negedge clk);
      sie_in_tok = 0;
      v = sie_resp_valid; nak = sie_resp_nak;
   endtask

   task automatic rd_byte(output logic [7:0] d);
      sie_rd = 1;
      #1 d = sie_rd_data;
      @(negedge clk);
      sie_rd = 0;
   endtask

   task automatic eop(input bit good);
      if (good) sie_eop_ok = 1; else sie_eop_bad = 1;
      @(negedge clk);
      sie_eop_ok = 0; sie_eop_bad = 0;
   endtask

   task automatic t_reset();
      chk("R1 empty", flg_empty, 1);
      chk("R1 flags", {flg_full, flg_underrun, flg_overflow, flg_ready}, 0);
      chk("R1 len", tx_len, 0);
      chk("R1 level", fill_level, 0);
      chk("R1 resp", sie_resp_valid, 0);
   endtask

   task automatic t_nak_then_send();
      logic v, n; logic [7:0] d;
      token(v, n);
      chk("R3 nak on empty", {v, n}, 2'b11);
      @(negedge clk);
      chk("R3 no token no resp", sie_resp_valid, 0);
      wr_byte(8'hA1); wr_byte(8'hA2); wr_byte(8'hA3);
      chk("R2 data only not ready", flg_ready, 0);
      token(v, n);
      chk("R3 nak without length", {v, n}, 2'b11);
      wr_hi(8'h00);
      chk("R2 hi only not ready", flg_ready, 0);
      wr_lo(8'h03);
      chk("R2 ready after lo", flg_ready, 1);
      chk("R6 len", tx_len, 16'h0003);
      token(v, n);
      chk("R4 grant", {v, n}, 2'b10);
      rd_byte(d); chk("R4 byte0", d, 8'hA1);
      rd_byte(d); chk("R4 byte1", d, 8'hA2);
      rd_byte(d); chk("R4 byte2", d, 8'hA3);
      eop(1);
      chk("R9 ready cleared", flg_ready, 0);
      chk("R9 empty", flg_empty, 1);
      chk("R4 no underrun", flg_underrun, 0);
   endtask

   task automatic t_len_halves();
      do_clr();
      wr_hi(8'h01);
      chk("R6 hi staged only", tx_len, 16'h0003);
      wr_lo(8'h20);
      chk("R6 commit both halves", tx_len, 16'h0120);
      wr_lo(8'h05);
      chk("R6 staged hi kept", tx_len, 16'h0105);
      fw_cnt_hi_we = 1; fw_cnt_lo_we = 1; fw_cnt_data = 8'h44;
      @(negedge clk);
      fw_cnt_hi_we = 0; fw_cnt_lo_we = 0;
      chk("R6 same cycle halves", tx_len, 16'h4444);
   endtask

   task automatic t_partial_release();
      logic v, n; logic [7:0] d;
      do_clr();
      wr_byte(8'h31); wr_byte(8'h32); wr_byte(8'h33);
      wr_lo(8'h03);
      token(v, n);
      rd_byte(d);
      eop(1);
      chk("R9 level after partial", fill_level, 2);
      chk("R9 disarmed", flg_ready, 0);
      token(v, n);
      chk("R9 nak after release", n, 1);
      wr_lo(8'h02);
      token(v, n);
      rd_byte(d);
      chk("R9 remainder first", d, 8'h32);
   endtask

   task automatic t_retry();
      logic v, n; logic [7:0] d;
      do_clr();
      wr_byte(8'h11); wr_byte(8'h22);
      wr_lo(8'h02);
      token(v, n);
      rd_byte(d);
      eop(0);
      chk("R10 still ready", flg_ready, 1);
      chk("R10 level kept", fill_level, 2);
      token(v, n);
      chk("R10 regrant", {v, n}, 2'b10);
      rd_byte(d); chk("R10 resend first", d, 8'h11);
      rd_byte(d); chk("R10 resend second", d, 8'h22);
      eop(1);
      chk("R9 empty after retry", flg_empty, 1);
   endtask

   task automatic t_underrun();
      logic v, n; logic [7:0] d;
      do_clr();
      wr_byte(8'h5A);
      wr_lo(8'h01);
      token(v, n);
      rd_byte(d); chk("R4 single byte", d, 8'h5A);
      rd_byte(d); chk("R5 zero on overread", d, 8'h00);
      chk("R5 underrun set", flg_underrun, 1);
      token(v, n);
      chk("R5 nak on underrun", {v, n}, 2'b11);
      wr_byte(8'h66); wr_lo(8'h01);
      token(v, n);
      chk("R5 nak despite new data", n, 1);
      chk("R5 still sticky", flg_underrun, 1);
      do_clr();
      chk("R7 underrun cleared", flg_underrun, 0);
      chk("R7 empty set", flg_empty, 1);
      chk("R7 not ready", flg_ready, 0);
   endtask

   task automatic t_setup();
      logic v, n; logic [7:0] d;
      do_clr();
      wr_byte(8'h71); wr_byte(8'h72); wr_lo(8'h02);
      setup_pend = 1;
      token(v, n);
      chk("R8 nak while setup", {v, n}, 2'b11);
      setup_pend = 0;
      @(negedge clk);
      token(v, n);
      chk("R8 data after setup drop", {v, n}, 2'b10);
      rd_byte(d); chk("R8 byte", d, 8'h71);
   endtask

   task automatic t_collide();
      do_clr();
      wr_byte(8'h81); wr_byte(8'h82); wr_lo(8'h02);
      setup_pend = 1;
      fw_clr = 1; sie_in_tok = 1; sie_rd = 1;
      @(negedge clk);
      fw_clr = 0; sie_in_tok = 0; sie_rd = 0;
      chk("R7 collide nak", {sie_resp_valid, sie_resp_nak}, 2'b11);
      chk("R7 collide no underrun", flg_underrun, 0);
      chk("R7 collide empty", flg_empty, 1);
      chk("R7 collide not ready", flg_ready, 0);
      setup_pend = 0;
      sie_rd = 1;
      @(negedge clk);
      sie_rd = 0;
      do_clr();
   endtask

   task automatic t_overflow();
      logic v, n; logic [7:0] d;
      do_clr();
      for (int i = 0; i < 8; i++) wr_byte(8'hC0 + 8'(i));
      chk("R11 full", flg_full, 1);
      chk("R11 no overflow yet", flg_overflow, 0);
      wr_byte(8'hEE);
      chk("R11 overflow", flg_overflow, 1);
      chk("R11 level held", fill_level, 8);
      wr_lo(8'h08);
      token(v, n);
      for (int i = 0; i < 8; i++) begin
         rd_byte(d);
         chk("R11 stored byte", d, 8'hC0 + 8'(i));
      end
      chk("R11 dropped byte absent", flg_underrun, 0);
      do_clr();
      chk("R7 overflow cleared", flg_overflow, 0);
   endtask

   initial begin
      #(20 * 100000);
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_nak_then_send();
      t_len_halves();
      t_partial_release();
      t_retry();
      t_underrun();
      t_setup();
      t_collide();
      t_overflow();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule